// File: doc/BRIEF.md
# Link Frame Packer with Checksum Trailer

This block sits in front of a serial link. It turns each packet on a 64-bit AXI4-Stream input into one link frame on a 64-bit AXI4-Stream output. The frame has four parts in this order: a fixed start word, the unchanged packet words, a fixed end marker word, and one trailer word. The trailer word lets the receiving side check the frame. It holds a word count and two checksums.

The first packet word is a header. Its bit 61 says whether a timestamp word follows it. The control checksum covers only the header, or the header plus the timestamp word when that bit is set. The payload checksum covers every later packet word and also the end marker. Both checksums are XNOR-feedback LFSR folds that take one 64-bit word per cycle, most significant bit first, and each starts from all ones. The output side can stall the block at any time, and during a stall no output word or internal tally moves. A synchronous clear stops a frame in progress and returns the block to idle.

Top module: `link_frame_packer`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `o_tvalid` and `i_tready` are both 0.
- R2: The first word of each frame is 64'h9E6774129E677412. It is presented before any packet word is accepted.
- R3: Packet words are forwarded unchanged and in order. `i_tready` is high only during the packet part of a frame, and only while `o_tready` is high.
- R4: The first output word after the packet word marked by `i_tlast` is 64'h2A1D632F2A1D632F.
- R5: Exactly one trailer word follows the end marker. `o_tlast` is 1 on the trailer and 0 on every other word. After the trailer transfers, `o_tvalid` drops until the next packet arrives.
- R6: Trailer bits [47:32] hold the packet word count plus one (the end marker is included).
- R7: Trailer bits [63:48] hold the 16-bit control checksum (polynomial 0x1021). It covers word 0 only, or words 0 and 1 when bit 61 of word 0 is set. On each bit, MSB first, the state shifts left and is XORed with the polynomial when its old MSB equals the data bit. The state starts at 16'hFFFF.
- R8: Trailer bits [31:0] hold the 32-bit payload checksum (polynomial 0x04C11DB7, same fold, start 32'hFFFFFFFF). It covers the packet words after the control region and then the end marker.
- R9: While `o_tvalid` is high and `o_tready` is low, `o_tvalid` stays high and `o_tdata` holds its value on the next cycle.
- R10: A cycle with `clr` high returns the block to idle: on the next cycle `o_tvalid` and `i_tready` are 0. The next packet then produces a complete, correct frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Synchronous clear, returns to idle |
| i_tdata | input | 64 | Packet word in |
| i_tvalid | input | 1 | Input word valid |
| i_tlast | input | 1 | Last word of the packet |
| i_tready | output | 1 | Block accepts the input word |
| o_tdata | output | 64 | Frame word out |
| o_tvalid | output | 1 | Output word valid |
| o_tlast | output | 1 | Marks the trailer word |
| o_tready | input | 1 | Downstream accepts the output word |

## Verification
Every output is decoded from the registered frame state without further delay. The start word appears on the cycle after `i_tvalid` is first seen in idle. A packet word appears on the same cycle it is offered. The end marker appears on the cycle after the handshake of the last packet word, and the trailer appears on the cycle after the end marker is taken. A scoreboard queue holds every expected frame word. The monitor samples on the falling edge and compares only on cycles where `o_tvalid` and `o_tready` are both high. This keeps the checks aligned with the real transfers under any stall pattern. For the stall rule, the monitor compares each stalled word with the word seen one cycle later.

// File: rtl/lfp_pkg.sv
package lfp_pkg;
  localparam int unsigned WORD_W   = 64;
  localparam int unsigned CTRL_W   = 16;
  localparam int unsigned CNT_W    = 16;
  localparam int unsigned PAY_W    = 32;
  localparam int unsigned TS_BIT   = 61;
  localparam logic [CTRL_W-1:0] CTRL_POLY = 16'h1021;
  localparam logic [PAY_W-1:0]  PAY_POLY  = 32'h04C11DB7;
  localparam logic [WORD_W-1:0] START_WORD = 64'h9E6774129E677412;
  localparam logic [WORD_W-1:0] END_WORD   = 64'h2A1D632F2A1D632F;

  typedef enum logic [2:0] {
    FS_IDLE  = 3'd0,
    FS_START = 3'd1,
    FS_BODY  = 3'd2,
    FS_END   = 3'd3,
    FS_TRAIL = 3'd4
  } frame_state_t;

  function automatic logic [WORD_W-1:0] pack_trailer(
    input logic [CTRL_W-1:0] c, input logic [CNT_W-1:0] n, input logic [PAY_W-1:0] p);
    return {c, n, p};
  endfunction
endpackage

// File: rtl/lfp_accum.sv
module lfp_accum #(
  parameter int unsigned W    = 16,
  parameter int unsigned DW   = 64,
  parameter logic [W-1:0] POLY = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init,
  input  logic          en,
  input  logic [DW-1:0] din,
  output logic [W-1:0]  sum
);
  localparam logic [W-1:0] SEED = '1;

  function automatic logic [W-1:0] fold_word(input logic [W-1:0] s, input logic [DW-1:0] d);
    logic [W-1:0] r;
    logic fb;
    r = s;
    for (int i = DW - 1; i >= 0; i--) begin
      fb = ~(r[W-1] ^ d[i]);
      r  = {r[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (rst || init) sum <= SEED;
    else if (en)     sum <= fold_word(sum, din);
  end

  // R8
  acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!init && !en) |=> $stable(sum));
  // R7
  acc_seed_chk: assert property (@(posedge clk) disable iff (rst)
    init |=> (sum == SEED));
endmodule

// File: rtl/lfp_seq.sv
module lfp_seq
  import lfp_pkg::*;
#(
  parameter int unsigned CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          i_tvalid,
  input  logic          i_tlast,
  input  logic          ts_flag,
  input  logic          o_tready,
  output frame_state_t  st,
  output logic          i_tready,
  output logic          o_tvalid,
  output logic          o_tlast,
  output logic          acc_init,
  output logic          ctrl_en,
  output logic          pay_en,
  output logic [CW-1:0] cnt
);
  frame_state_t st_nx;
  logic ts_q;
  logic in_xfer;
  logic end_xfer;
  logic in_ctrl;

  assign i_tready = (st == FS_BODY) && o_tready;
  assign o_tvalid = (st == FS_START) || (st == FS_END) || (st == FS_TRAIL) ||
                    ((st == FS_BODY) && i_tvalid);
  assign o_tlast  = (st == FS_TRAIL);
  assign in_xfer  = i_tvalid && i_tready;
  assign end_xfer = (st == FS_END) && o_tready;
  assign in_ctrl  = (cnt == '0) || ((cnt == CW'(1)) && ts_q);
  assign acc_init = (st == FS_START) && o_tready;
  assign ctrl_en  = in_xfer && in_ctrl;
  assign pay_en   = (in_xfer && !in_ctrl) || end_xfer;

  always_comb begin
    st_nx = st;
    unique case (st)
      FS_IDLE:  if (i_tvalid)           st_nx = FS_START;
      FS_START: if (o_tready)           st_nx = FS_BODY;
      FS_BODY:  if (in_xfer && i_tlast) st_nx = FS_END;
      FS_END:   if (o_tready)           st_nx = FS_TRAIL;
      FS_TRAIL: if (o_tready)           st_nx = FS_IDLE;
      default:                          st_nx = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      st   <= FS_IDLE;
      cnt  <= '0;
      ts_q <= 1'b0;
    end else begin
      st <= st_nx;
      if (acc_init) begin
        cnt  <= '0;
        ts_q <= 1'b0;
      end else begin
        if (in_xfer || end_xfer) cnt <= cnt + CW'(1);
        if (in_xfer && (cnt == '0)) ts_q <= ts_flag;
      end
    end
  end

  // R1
  rst_idle_chk: assert property (@(posedge clk)
    rst |=> (!o_tvalid && !i_tready));
  // R3
  in_gate_chk: assert property (@(posedge clk) disable iff (rst)
    i_tready |-> o_tready);
  // R4
  end_next_chk: assert property (@(posedge clk) disable iff (rst || clr)
    (in_xfer && i_tlast) |=> (o_tvalid && st == FS_END));
  // R5
  last_end_chk: assert property (@(posedge clk) disable iff (rst || clr)
    (o_tvalid && o_tready && o_tlast) |=> !o_tvalid);
  // R6
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst || clr)
    end_xfer |=> (cnt == $past(cnt) + CW'(1)));
  // R9
  stall_state_chk: assert property (@(posedge clk) disable iff (rst || clr)
    (o_tvalid && !o_tready && st != FS_BODY) |=> (o_tvalid && $stable(st) && $stable(cnt)));
  // R10
  clr_idle_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!o_tvalid && !i_tready));
endmodule

// File: rtl/link_frame_packer.sv
module link_frame_packer
  import lfp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic [WORD_W-1:0] i_tdata,
  input  logic              i_tvalid,
  input  logic              i_tlast,
  output logic              i_tready,
  output logic [WORD_W-1:0] o_tdata,
  output logic              o_tvalid,
  output logic              o_tlast,
  input  logic              o_tready
);
  frame_state_t        st;
  logic                acc_init;
  logic                ctrl_en;
  logic                pay_en;
  logic [CNT_W-1:0]    cnt;
  logic [CTRL_W-1:0]   ctrl_sum;
  logic [PAY_W-1:0]    pay_sum;
  logic [WORD_W-1:0]   pay_din;

  lfp_seq #(.CW(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .clr(clr),
    .i_tvalid(i_tvalid), .i_tlast(i_tlast), .ts_flag(i_tdata[TS_BIT]),
    .o_tready(o_tready), .st(st), .i_tready(i_tready),
    .o_tvalid(o_tvalid), .o_tlast(o_tlast),
    .acc_init(acc_init), .ctrl_en(ctrl_en), .pay_en(pay_en), .cnt(cnt)
  );

  assign pay_din = (st == FS_END) ? END_WORD : i_tdata;

  lfp_accum #(.W(CTRL_W), .DW(WORD_W), .POLY(CTRL_POLY)) u_ctrl (
    .clk(clk), .rst(rst || clr), .init(acc_init), .en(ctrl_en),
    .din(i_tdata), .sum(ctrl_sum)
  );

  lfp_accum #(.W(PAY_W), .DW(WORD_W), .POLY(PAY_POLY)) u_pay (
    .clk(clk), .rst(rst || clr), .init(acc_init), .en(pay_en),
    .din(pay_din), .sum(pay_sum)
  );

  always_comb begin
    unique case (st)
      FS_START: o_tdata = START_WORD;
      FS_BODY:  o_tdata = i_tdata;
      FS_END:   o_tdata = END_WORD;
      FS_TRAIL: o_tdata = pack_trailer(ctrl_sum, cnt, pay_sum);
      default:  o_tdata = '0;
    endcase
  end

  // R9
  word_hold_chk: assert property (@(posedge clk) disable iff (rst || clr)
    (o_tvalid && !o_tready && st != FS_BODY) |=> $stable(o_tdata));
  // R7
  ctrl_frozen_chk: assert property (@(posedge clk) disable iff (rst || clr)
    (st == FS_END || st == FS_TRAIL) |=> $stable(ctrl_sum));
  // R8
  pay_after_end_chk: assert property (@(posedge clk) disable iff (rst || clr)
    (st == FS_TRAIL) |=> $stable(pay_sum));
endmodule

// File: tb/test_link_frame_packer.sv
module test_link_frame_packer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clr = 1'b0;
  logic [63:0] i_tdata = '0;
  logic        i_tvalid = 1'b0;
  logic        i_tlast = 1'b0;
  logic        i_tready;
  logic [63:0] o_tdata;
  logic        o_tvalid;
  logic        o_tlast;
  logic        o_tready = 1'b1;

  always #10 clk = ~clk;

  link_frame_packer i_link_frame_packer (
    .clk(clk), .rst(rst), .clr(clr),
    .i_tdata(i_tdata), .i_tvalid(i_tvalid), .i_tlast(i_tlast), .i_tready(i_tready),
    .o_tdata(o_tdata), .o_tvalid(o_tvalid), .o_tlast(o_tlast), .o_tready(o_tready)
  );

  typedef struct { logic [63:0] d; logic l; int k; } exp_t;
  exp_t q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit mon_en = 1'b0;
  int stall_pct = 0;
  bit prev_stall = 1'b0;
  logic [63:0] prev_d = '0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] sum16(input logic [15:0] s, input logic [63:0] d);
    for (int b = 63; b >= 0; b--) begin
      logic top;
      top = s[15];
      s = s << 1;
      if (top == d[b]) s = s ^ 16'h1021;
    end
    return s;
  endfunction

  function automatic logic [31:0] sum32(input logic [31:0] s, input logic [63:0] d);
    for (int b = 63; b >= 0; b--) begin
      logic top;
      top = s[31];
      s = s << 1;
      if (top == d[b]) s = s ^ 32'h04C11DB7;
    end
    return s;
  endfunction

  task automatic push(input logic [63:0] d, input logic l, input int k);
    exp_t e;
    e.d = d; e.l = l; e.k = k;
    q.push_back(e);
  endtask

  task automatic send_pkt(input int n, input bit ts, input int gap_pct);
    logic [63:0] w[$];
    logic [15:0] cs;
    logic [31:0] ps;
    int clen;
    bit hs;
    for (int i = 0; i < n; i++) begin
      logic [63:0] v;
      v = {$urandom, $urandom};
      if (i == 0) v[61] = ts;
      w.push_back(v);
    end
    clen = ts ? 2 : 1;
    cs = 16'hFFFF;
    ps = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      if (i < clen) cs = sum16(cs, w[i]);
      else          ps = sum32(ps, w[i]);
    end
    ps = sum32(ps, 64'h2A1D632F2A1D632F);
    push(64'h9E6774129E677412, 1'b0, 2);
    for (int i = 0; i < n; i++) push(w[i], 1'b0, 3);
    push(64'h2A1D632F2A1D632F, 1'b0, 4);
    push({cs, 16'(n + 1), ps}, 1'b1, 5);
    for (int i = 0; i < n; i++) begin
      while (($urandom % 100) < gap_pct) begin
        i_tvalid = 1'b0;
        @(posedge clk); #1;
      end
      i_tdata = w[i];
      i_tlast = (i == n - 1);
      i_tvalid = 1'b1;
      do begin
        @(negedge clk);
        hs = i_tready;
        @(posedge clk); #1;
      end while (!hs);
    end
    i_tvalid = 1'b0;
    i_tlast = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    forever begin
      @(posedge clk); #1;
      o_tready = (($urandom % 100) >= stall_pct);
    end
  end

  always @(negedge clk) begin
    if (mon_en) begin
      if (prev_stall) chk(o_tvalid && (o_tdata == prev_d), "R9 stalled word held", o_tdata, prev_d);
      if (o_tvalid && o_tready) begin
        if (q.size() == 0) begin
          chk(1'b0, "R5 word after frame end", o_tdata, '0);
        end else begin
          exp_t e;
          e = q.pop_front();
          case (e.k)
            2: chk(o_tdata == e.d, "R2 start word", o_tdata, e.d);
            3: chk(o_tdata == e.d, "R3 packet word", o_tdata, e.d);
            4: chk(o_tdata == e.d, "R4 end marker", o_tdata, e.d);
            default: begin
              chk(o_tdata[47:32] == e.d[47:32], "R6 word count", 64'(o_tdata[47:32]), 64'(e.d[47:32]));
              chk(o_tdata[63:48] == e.d[63:48], "R7 control checksum", 64'(o_tdata[63:48]), 64'(e.d[63:48]));
              chk(o_tdata[31:0] == e.d[31:0], "R8 payload checksum", 64'(o_tdata[31:0]), 64'(e.d[31:0]));
            end
          endcase
          chk(o_tlast == e.l, "R5 tlast placement", 64'(o_tlast), 64'(e.l));
        end
      end
      prev_stall = o_tvalid && !o_tready;
      prev_d = o_tdata;
    end else begin
      prev_stall = 1'b0;
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", q.size());
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!o_tvalid && !i_tready, "R1 reset idle", {o_tvalid, i_tready}, 0);
    @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    chk(!o_tvalid && !i_tready, "R1 idle after reset", {o_tvalid, i_tready}, 0);
    @(posedge clk); #1;
    mon_en = 1'b1;

    stall_pct = 0;
    send_pkt(4, 1'b0, 0);  drain();
    send_pkt(5, 1'b1, 0);  drain();
    stall_pct = 40;
    send_pkt(1, 1'b0, 30); drain();
    send_pkt(1, 1'b1, 30); drain();
    send_pkt(2, 1'b1, 30); drain();
    send_pkt(7, 1'b0, 20); drain();
    send_pkt(12, 1'b1, 20);
    send_pkt(3, 1'b0, 0);  drain();
    stall_pct = 70;
    for (int p = 0; p < 10; p++) begin
      send_pkt(1 + ($urandom % 16), 1'($urandom), 25);
    end
    drain();

    // R10: clear in the middle of a frame
    mon_en = 1'b0;
    stall_pct = 0;
    @(posedge clk); #1;
    i_tdata = 64'h0123_4567_89AB_CDEF;
    i_tvalid = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    clr = 1'b1;
    i_tvalid = 1'b0;
    @(posedge clk); #1;
    clr = 1'b0;
    @(negedge clk);
    chk(!o_tvalid && !i_tready, "R10 idle after clear", {o_tvalid, i_tready}, 0);
    q.delete();
    @(posedge clk); #1;
    mon_en = 1'b1;
    stall_pct = 30;
    send_pkt(3, 1'b1, 10); drain();
    chk(q.size() == 0, "R10 frame after clear complete", q.size(), 0);

    finish_run();
  end
endmodule